// File: doc/BRIEF.md
# Processor Idle Clock Gate Controller

This block stops and restarts the clock of a processor core so the core can sit in an idle mode. Software asks for the stop by writing a small register. The controller does not cut the clock straight away. It waits until the core reports, on a handshake input, that the instruction in progress has finished, and only then removes the clock. Once stopped, the core clock comes back by hardware alone when an interrupt request arrives whose enable bit is set. Fast and normal requests have separate enable masks. A reset also brings the clock back.

The register port and the controller run on a free-running clock that is never gated. Bus traffic from other masters therefore keeps going while the core is stopped. The core clock passes through a latch-based gate. The gate samples its enable only while the free-running clock is low, so the gated clock never carries a shortened pulse. A status bit, available both as a port and in a readable register, shows whether the core clock is running.

Register map (word index on `addr`, `DATA_W`-bit data). Index 0 is the stop-request register, which is write-only and reads 0. Index 1 is status: bit 0 is 1 while the core clock runs and all other bits are 0. Index 2 holds the fast enable mask and index 3 the normal enable mask. Both are read/write and use bit i for source i. Reads are combinational. Writes take effect at the clock edge on which `wrEn` is high.

Top module: `idle_clk_gate`

## Requirements
- R1: Reset (`rstN` low, asynchronous) puts the controller in the running state. `coreRunning` reads 1, status bit 0 reads 1, and both enable masks read 0.
- R2: Writing a 1 in bit 0 of index 0 while running, with no enabled request present, creates a pending stop. The core clock keeps running while the stop is pending.
- R3: `coreRunning`, `coreClkEn` (sampled while `clk` is low) and status bit 0 are 1 in every state except stopped, and 0 when stopped. The other status bits read 0.
- R4: While stopped, a fast request whose enable bit is set returns the controller to running on the next `clk` edge, and gated clock edges resume.
- R5: While stopped, a normal request whose enable bit is set returns the controller to running on the next `clk` edge.
- R6: A pending stop becomes stopped at the `clk` edge where `instrDone` is 1, and not before. While stopped, `coreClk` has no rising edges.
- R7: An enabled request during a pending stop cancels the stop and returns to running, even when `instrDone` is 1 in the same cycle.
- R8: A request whose mask bit is 0 does not wake the core. A write to index 2 or 3 loads that mask, and the mask reads back unchanged.
- R9: A write to index 0 with bit 0 equal to 0 has no effect on the gating state, and index 0 reads as 0.
- R10: Asserting reset while stopped makes `coreRunning` 1 at once, without waiting for a clock edge.
- R11: While running, `coreClk` has exactly one rising edge for each rising edge of `clk`.
- R12: A stop write while an enabled request is present is ignored, and the core stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for the registers and the controller |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word index |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` (combinational) |
| fastIrq | input | NUM_FAST | Fast interrupt requests, synchronous to `clk` |
| normIrq | input | NUM_NORM | Normal interrupt requests, synchronous to `clk` |
| instrDone | input | 1 | Core handshake: the current instruction has completed |
| coreClk | output | 1 | Gated core clock |
| coreClkEn | output | 1 | Latched gate enable |
| coreRunning | output | 1 | Status: the core clock is running |

## Verification
A wrong internal state shows at the ports within one `clk` cycle. A controller stuck in the pending or running state keeps `coreRunning` high after `instrDone`. An early stop drops `coreRunning` and `coreClkEn` one cycle before the model does. A missed wake leaves the gated clock without edges while the model counts them. The bench compares status, latched enable and read data against a behavioural model on every cycle, and counts `coreClk` edges over fixed windows.

// File: rtl/idle_gate_pkg.sv
package idle_gate_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_STOP = 2'd2
  } gateState_e;

  // control -> datapath
  typedef struct packed {
    logic gateEn;
    logic running;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic stopReq;
    logic wake;
  } dpFlags_t;

  localparam int OFS_STOP   = 0;
  localparam int OFS_STATUS = 1;
  localparam int OFS_FMASK  = 2;
  localparam int OFS_NMASK  = 3;

endpackage

// File: rtl/idle_gate_cell.sv
module idle_gate_cell (
  input  logic clk,
  input  logic en,
  output logic enLat,
  output logic gclk
);

  // transparent while clk is low: the enable only changes in the low phase
  always_latch begin
    if (!clk) enLat = en;
  end

  assign gclk = clk & enLat;

endmodule

// File: rtl/idle_gate_dp.sv
module idle_gate_dp
  import idle_gate_pkg::*;
#(
  parameter int NUM_FAST = 1,
  parameter int NUM_NORM = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_FAST-1:0] fastIrq,
  input  logic [NUM_NORM-1:0] normIrq,
  input  ctrlStrobe_t         strobe,
  output dpFlags_t            flags
);

  localparam logic [ADDR_W-1:0] A_STOP   = ADDR_W'(OFS_STOP);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_FMASK  = ADDR_W'(OFS_FMASK);
  localparam logic [ADDR_W-1:0] A_NMASK  = ADDR_W'(OFS_NMASK);

  logic [NUM_FAST-1:0] fastMask;
  logic [NUM_NORM-1:0] normMask;
  logic [NUM_FAST-1:0] fastHit;
  logic [NUM_NORM-1:0] normHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastMask <= '0;
      normMask <= '0;
    end else if (wrEn) begin
      if (addr == A_FMASK) fastMask <= wrData[NUM_FAST-1:0];
      if (addr == A_NMASK) normMask <= wrData[NUM_NORM-1:0];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FAST; gi++) begin : g_fast
      assign fastHit[gi] = fastIrq[gi] & fastMask[gi];
    end
    for (gi = 0; gi < NUM_NORM; gi++) begin : g_norm
      assign normHit[gi] = normIrq[gi] & normMask[gi];
    end
  endgenerate

  assign flags.wake    = (|fastHit) | (|normHit);
  assign flags.stopReq = wrEn && (addr == A_STOP) && wrData[0];

  always_comb begin
    rdData = '0;
    case (addr)
      A_STATUS: rdData[0] = strobe.running;
      A_FMASK:  rdData[NUM_FAST-1:0] = fastMask;
      A_NMASK:  rdData[NUM_NORM-1:0] = normMask;
      default:  rdData = '0;
    endcase
  end

  // R8
  fast_mask_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_FMASK) |=> (fastMask == $past(wrData[NUM_FAST-1:0])));

  // R8
  norm_mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == A_NMASK) |=> $stable(normMask));

endmodule

// File: rtl/idle_gate_ctrl.sv
module idle_gate_ctrl
  import idle_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpFlags_t    flags,
  input  logic        instrDone,
  output ctrlStrobe_t strobe
);

  gateState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      ST_RUN:  if (flags.stopReq && !flags.wake) stateNxt = ST_PEND;
      ST_PEND: begin
        if (flags.wake)     stateNxt = ST_RUN;
        else if (instrDone) stateNxt = ST_STOP;
      end
      ST_STOP: if (flags.wake) stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  assign strobe.gateEn  = (state != ST_STOP);
  assign strobe.running = (state != ST_STOP);

  // R6
  pend_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && !flags.wake && !instrDone) |=> (state == ST_PEND));

  // R6
  no_direct_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |=> (state != ST_STOP));

  // R4 R5
  wake_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && flags.wake) |=> (state == ST_RUN));

  // R8
  stay_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !flags.wake) |=> (state == ST_STOP));

  // R7
  cancel_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND && flags.wake) |=> (state == ST_RUN));

  // R12
  stop_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && flags.wake) |=> (state == ST_RUN));

endmodule

// File: rtl/idle_clk_gate.sv
module idle_clk_gate
  import idle_gate_pkg::*;
#(
  parameter int NUM_FAST = 1,
  parameter int NUM_NORM = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_FAST-1:0] fastIrq,
  input  logic [NUM_NORM-1:0] normIrq,
  input  logic                instrDone,
  output logic                coreClk,
  output logic                coreClkEn,
  output logic                coreRunning
);

  ctrlStrobe_t strobe;
  dpFlags_t    flags;

  idle_gate_dp #(
    .NUM_FAST(NUM_FAST), .NUM_NORM(NUM_NORM),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .fastIrq(fastIrq), .normIrq(normIrq),
    .strobe(strobe), .flags(flags)
  );

  idle_gate_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .instrDone(instrDone),
    .strobe(strobe)
  );

  idle_gate_cell i_cell (
    .clk(clk), .en(strobe.gateEn), .enLat(coreClkEn), .gclk(coreClk)
  );

  assign coreRunning = strobe.running;

endmodule

// File: tb/test_idle_clk_gate.sv
module test_idle_clk_gate;

  localparam int NF = 1;
  localparam int NN = 8;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NF-1:0] fastIrq = '0;
  logic [NN-1:0] normIrq = '0;
  logic          instrDone = 1'b0;
  logic          coreClk, coreClkEn, coreRunning;

  idle_clk_gate #(.NUM_FAST(NF), .NUM_NORM(NN), .DATA_W(DW), .ADDR_W(AW)) i_idle_clk_gate (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .fastIrq(fastIrq), .normIrq(normIrq),
    .instrDone(instrDone), .coreClk(coreClk), .coreClkEn(coreClkEn),
    .coreRunning(coreRunning)
  );

  always #5 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  int gEdges = 0;
  string phaseTag = "R1";

  // behavioural reference: 0 running, 1 stop pending, 2 stopped
  int mState = 0;
  logic [NF-1:0] mFast = '0;
  logic [NN-1:0] mNorm = '0;

  always @(posedge coreClk) gEdges++;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mFast = '0; mNorm = '0;
    end else begin
      bit wake, stopWr;
      wake   = ((fastIrq & mFast) != 0) || ((normIrq & mNorm) != 0);
      stopWr = wrEn && addr == 0 && wrData[0];
      case (mState)
        0: if (stopWr && !wake) mState = 1;
        1: if (wake) mState = 0; else if (instrDone) mState = 2;
        default: if (wake) mState = 0;
      endcase
      if (wrEn && addr == 2) mFast = wrData[NF-1:0];
      if (wrEn && addr == 3) mNorm = wrData[NN-1:0];
    end
  end

  function automatic logic [DW-1:0] expRead(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      1: v[0] = (mState != 2);
      2: v[NF-1:0] = mFast;
      3: v[NN-1:0] = mNorm;
      default: v = '0;
    endcase
    return v;
  endfunction

  // per-cycle comparison in the low phase
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      check(phaseTag, "coreRunning", DW'(coreRunning), DW'(mState != 2));
      check(phaseTag, "coreClkEn", DW'(coreClkEn), DW'(mState != 2));
      check(phaseTag, "rdData", rdData, expRead(addr));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic wrReg(logic [AW-1:0] a, logic [DW-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick(1);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseDone();
    instrDone = 1'b1;
    tick(1);
    instrDone = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    addr = a;
    #1;
    check(tag, "read", rdData, exp);
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finishTest();
  end

  initial begin
    int e0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    phaseTag = "R1";
    check("R1", "coreRunning", DW'(coreRunning), 1);
    rdChk("R1", 1, 1);
    rdChk("R1", 2, 0);
    rdChk("R1", 3, 0);
    rdChk("R9", 0, 0);

    // R8 mask writes read back
    phaseTag = "R8";
    wrReg(2, 32'h1);
    wrReg(3, 32'h0F);
    rdChk("R8", 2, 32'h1);
    rdChk("R8", 3, 32'h0F);

    // R2 / R6 stop request waits for instruction completion
    phaseTag = "R2";
    wrReg(0, 32'h1);
    tick(3);
    check("R2", "running while pending", DW'(coreRunning), 1);
    e0 = gEdges;
    tick(4);
    check("R2", "clock edges while pending", DW'(gEdges - e0), 4);
    phaseTag = "R6";
    pulseDone();
    check("R6", "stopped after done", DW'(coreRunning), 0);
    rdChk("R3", 1, 0);
    tick(1);
    e0 = gEdges;
    tick(5);
    check("R6", "no gated edges when stopped", DW'(gEdges - e0), 0);

    // R8 masked normal requests do not wake
    phaseTag = "R8";
    normIrq = 8'hF0;
    tick(4);
    check("R8", "masked irq no wake", DW'(coreRunning), 0);

    // R5 enabled normal request wakes
    phaseTag = "R5";
    normIrq = 8'h01;
    tick(1);
    check("R5", "normal wake", DW'(coreRunning), 1);
    normIrq = '0;
    tick(1);
    // R11 one gated edge per clk edge
    phaseTag = "R11";
    e0 = gEdges;
    tick(5);
    check("R11", "gated edges while running", DW'(gEdges - e0), 5);

    // R4 fast wake
    phaseTag = "R4";
    wrReg(0, 32'h1);
    pulseDone();
    check("R4", "stopped before fast irq", DW'(coreRunning), 0);
    fastIrq = 1'b1;
    tick(1);
    check("R4", "fast wake", DW'(coreRunning), 1);
    fastIrq = '0;
    tick(1);
    e0 = gEdges;
    tick(3);
    check("R4", "edges after fast wake", DW'(gEdges - e0), 3);

    // R7 cancel during pending, wake beats instrDone
    phaseTag = "R7";
    wrReg(0, 32'h1);
    normIrq = 8'h02; instrDone = 1'b1;
    tick(1);
    normIrq = '0; instrDone = 1'b0;
    tick(3);
    check("R7", "stop cancelled", DW'(coreRunning), 1);
    pulseDone();
    check("R7", "done after cancel ignored", DW'(coreRunning), 1);

    // R12 stop write ignored with enabled request present
    phaseTag = "R12";
    normIrq = 8'h04;
    wrReg(0, 32'h1);
    normIrq = '0;
    pulseDone();
    check("R12", "stop write ignored", DW'(coreRunning), 1);

    // R9 zero write has no effect
    phaseTag = "R9";
    wrReg(0, 32'hFFFF_FFFE);
    pulseDone();
    check("R9", "zero write no stop", DW'(coreRunning), 1);
    rdChk("R9", 0, 0);

    // R10 reset wakes a stopped core
    phaseTag = "R10";
    wrReg(0, 32'h1);
    pulseDone();
    check("R10", "stopped before reset", DW'(coreRunning), 0);
    rstN = 1'b0;
    #1;
    check("R10", "running in reset", DW'(coreRunning), 1);
    tick(2);
    rstN = 1'b1;
    tick(1);
    phaseTag = "R1";
    rdChk("R1", 2, 0);
    rdChk("R1", 3, 0);
    // masks cleared: a request no longer wakes
    phaseTag = "R8";
    wrReg(0, 32'h1);
    pulseDone();
    normIrq = 8'hFF; fastIrq = 1'b1;
    tick(3);
    check("R8", "all masked after reset", DW'(coreRunning), 0);
    normIrq = '0; fastIrq = '0;
    tick(2);
    finishTest();
  end

endmodule